// File: doc/BRIEF.md
# SD Card Write-Start Busy Sequencer

This block starts write transfers to an SD card only once the card has shown it can take data. A start request first makes it ask for the card's status, through a separate command engine, with the status command (index 13). It repeats that request until the status word reports ready and the DAT0 line is released high. Only then does it issue the write command: index 24 for one block, or index 25 for several. After the write command's response has come back clean, it enables the data path with the transfer length and block size. It reports completion when the data path signals that its remaining byte count has reached zero. It never reports completion from a transmit-activity flag, because in a multi-block write the card may still be in its receive-data state after every byte has been sent.

The sequencer is a single state machine with eight states. S_IDLE waits for a start and takes S_IDLE→S_POLL_CMD on it. S_POLL_CMD holds the status request until accepted (S_POLL_CMD→S_POLL_WAIT). S_POLL_WAIT classifies the response. A ready card takes S_POLL_WAIT→S_WR_CMD. A not-ready card takes S_POLL_WAIT→S_POLL_CMD, or S_POLL_WAIT→S_FAIL once the poll limit is used up. An error or timeout takes S_POLL_WAIT→S_FAIL. S_WR_CMD holds the write request until accepted (S_WR_CMD→S_WR_WAIT). S_WR_WAIT goes to S_DATA on a clean response and to S_FAIL on an error or timeout. S_DATA keeps the data path enabled until data-end (S_DATA→S_FINISH). S_FINISH and S_FAIL each last one cycle and return to S_IDLE.

The command engine, CRC handling and the data path are separate blocks. This block only exchanges handshakes with them.

Top module: `sd_wrstart_seq`

## Requirements
- R1: During and after reset, cmd_req_o, dp_en_o, done_o and err_o are low and err_code_o is 0.
- R2: A start_i seen in S_IDLE makes the block raise cmd_req_o with cmd_idx_o = 13 and cmd_arg_o = {rca_i, 16'h0000}. The request and its index and argument stay unchanged until the cycle in which cmd_ack_i is high.
- R3: A status response counts as ready only when rsp_valid_i is high, bit 8 of rsp_data_i is 1, DAT0 (dat0_i) is high in that same cycle, and no error bit is set. Any other valid, error-free status response makes the block issue the status command again.
- R4: After a ready response, the write command is issued with cmd_idx_o = 24 when multi_i was 0 at start, or 25 when it was 1. Its argument is the addr_i captured at start.
- R5: dp_en_o rises only after the write command's response arrives with no error and no timeout. While it is high, dp_len_o equals 512 for a single-block write or nblk_i × 512 for a multi-block write, and dp_bsize_o equals 9.
- R6: dp_en_o stays high until dp_end_i is seen. One cycle later, done_o pulses high for exactly one cycle, dp_en_o falls, and the block returns to idle.
- R7: The block counts not-ready status responses. When that count reaches poll_limit_i (a limit of 0 acts as 1), err_o pulses with err_code_o = 1 and no write command is issued.
- R8: A response with any of bits 31 to 19 of rsp_data_i set ends the sequence: err_o pulses with err_code_o = 2 and dp_en_o is never raised. This applies to both the status response and the write response.
- R9: rsp_timeout_i ends the sequence with err_code_o = 3 and no data enable, whether it comes while waiting for the status response or the write response. It takes priority over a simultaneous rsp_valid_i.
- R10: start_i is ignored outside S_IDLE. The captured address, mode and block count of a running sequence do not change.
- R11: At most one of cmd_req_o, dp_en_o, done_o and err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a write-start sequence (taken only in idle) |
| multi_i | input | 1 | 1 selects a multi-block write, 0 a single block |
| addr_i | input | 32 | Card block address for the write command |
| nblk_i | input | NBLK_W | Block count for a multi-block write |
| rca_i | input | RCA_W | Card relative address placed in the status command |
| poll_limit_i | input | POLL_W | Largest number of not-ready status responses allowed |
| cmd_req_o | output | 1 | Command request to the command engine |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_ack_i | input | 1 | Command engine accepted the request |
| rsp_valid_i | input | 1 | Response word is valid |
| rsp_timeout_i | input | 1 | Command engine saw no response in time |
| rsp_data_i | input | 32 | Card status word of the response |
| dat0_i | input | 1 | DAT0 line sense, low while the card is busy |
| dp_en_o | output | 1 | Data-path enable |
| dp_len_o | output | NBLK_W+9 | Transfer length in bytes |
| dp_bsize_o | output | 4 | Block size as log2 of bytes |
| dp_end_i | input | 1 | Data path's remaining byte count reached zero |
| done_o | output | 1 | One-cycle pulse: transfer complete |
| err_o | output | 1 | One-cycle pulse: sequence aborted |
| err_code_o | output | 2 | 1 poll limit, 2 card error bit, 3 response timeout; held until next start |

## Verification
The bench builds the block with NBLK_W = 8 and POLL_W = 4. These values keep every poll limit, including the largest (15), small enough to exhaust in a few dozen cycles. The bench can therefore hit the limit exactly, stay one poll under it, and use a limit of zero. A 255-block multi-block write exercises the top of the length field. The modelled command engine can make each status response busy, make it ready while DAT0 is still low, or inject an error bit or a timeout into the status or the write response. This lets the bench reach every exit of S_POLL_WAIT and S_WR_WAIT.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_CMD,
        S_POLL_WAIT,
        S_WR_CMD,
        S_WR_WAIT,
        S_DATA,
        S_FINISH,
        S_FAIL
    } sdw_state_e;

    typedef enum logic [1:0] {
        E_NONE     = 2'd0,
        E_POLL_TMO = 2'd1,
        E_CARD_ERR = 2'd2,
        E_RSP_TMO  = 2'd3
    } sdw_err_e;

    typedef enum logic [2:0] {
        RC_NONE,
        RC_TMO,
        RC_ERR,
        RC_BUSY,
        RC_GO
    } sdw_rsp_e;

    localparam int          ARG_W       = 32;
    localparam logic [5:0]  IDX_STATUS  = 6'd13;
    localparam logic [5:0]  IDX_WR_ONE  = 6'd24;
    localparam logic [5:0]  IDX_WR_MANY = 6'd25;
    localparam int          READY_BIT   = 8;
    localparam logic [31:0] ERR_MASK    = 32'hFFF8_0000;
    localparam int          BLK_SHIFT   = 9;
    localparam logic [3:0]  BSIZE_LOG2  = 4'(BLK_SHIFT);

endpackage

// File: rtl/sdw_rsp_eval.sv
module sdw_rsp_eval
    import sdw_pkg::*;
(
    input  logic        rsp_valid_i,
    input  logic        rsp_timeout_i,
    input  logic [31:0] rsp_data_i,
    input  logic        dat0_i,
    output sdw_rsp_e    rc_o
);

    logic err_hit;
    logic rdy_hit;

    assign err_hit = |(rsp_data_i & ERR_MASK);
    assign rdy_hit = rsp_data_i[READY_BIT] & dat0_i;

    // Priority: timeout, no response, card error, ready, busy.
    always_comb begin
        if (rsp_timeout_i) begin
            rc_o = RC_TMO;
        end else if (!rsp_valid_i) begin
            rc_o = RC_NONE;
        end else if (err_hit) begin
            rc_o = RC_ERR;
        end else if (rdy_hit) begin
            rc_o = RC_GO;
        end else begin
            rc_o = RC_BUSY;
        end
    end

endmodule

// File: rtl/sdw_poll_ctr.sv
module sdw_poll_ctr #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              bump_i,
    input  logic [POLL_W-1:0] limit_i,
    output logic              last_o
);

    localparam int EXT_W = POLL_W + 1;

    logic [POLL_W-1:0] cnt_q;
    logic [EXT_W-1:0]  cnt_next_ext;

    assign cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
    // The response being judged is the final one allowed; limit 0 acts as 1.
    assign last_o = cnt_next_ext >= {1'b0, limit_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (bump_i && !last_o) begin
            cnt_q <= cnt_q + POLL_W'(1);
        end
    end

    // R7: the counter never passes the programmed limit.
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q < limit_i));

endmodule

// File: rtl/sdw_cmd_build.sv
module sdw_cmd_build
    import sdw_pkg::*;
#(
    parameter int RCA_W = 16
) (
    input  logic             sel_status_i,
    input  logic             multi_i,
    input  logic [RCA_W-1:0] rca_i,
    input  logic [31:0]      addr_i,
    output logic [5:0]       idx_o,
    output logic [31:0]      arg_o
);

    localparam int PAD_W = ARG_W - RCA_W;

    always_comb begin
        if (sel_status_i) begin
            idx_o = IDX_STATUS;
            arg_o = {rca_i, {PAD_W{1'b0}}};
        end else begin
            idx_o = multi_i ? IDX_WR_MANY : IDX_WR_ONE;
            arg_o = addr_i;
        end
    end

endmodule

// File: rtl/sd_wrstart_seq.sv
module sd_wrstart_seq
    import sdw_pkg::*;
#(
    parameter int NBLK_W = 16,
    parameter int POLL_W = 16,
    parameter int RCA_W  = 16,
    parameter int LEN_W  = NBLK_W + BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              multi_i,
    input  logic [31:0]       addr_i,
    input  logic [NBLK_W-1:0] nblk_i,
    input  logic [RCA_W-1:0]  rca_i,
    input  logic [POLL_W-1:0] poll_limit_i,
    output logic              cmd_req_o,
    output logic [5:0]        cmd_idx_o,
    output logic [31:0]       cmd_arg_o,
    input  logic              cmd_ack_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_timeout_i,
    input  logic [31:0]       rsp_data_i,
    input  logic              dat0_i,
    output logic              dp_en_o,
    output logic [LEN_W-1:0]  dp_len_o,
    output logic [3:0]        dp_bsize_o,
    input  logic              dp_end_i,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o
);

    localparam logic [LEN_W-1:0] ONE_BLK_LEN = LEN_W'(1) << BLK_SHIFT;

    sdw_state_e        state_q, state_d;
    sdw_err_e          code_q, code_d;
    sdw_rsp_e          rc;
    logic              accept;
    logic              poll_last;
    logic              poll_bump;
    logic              sel_status;
    logic              multi_q;
    logic [31:0]       addr_q;
    logic [NBLK_W-1:0] nblk_q;
    logic [RCA_W-1:0]  rca_q;
    logic [POLL_W-1:0] limit_q;

    assign accept    = (state_q == S_IDLE) && start_i;
    assign poll_bump = (state_q == S_POLL_WAIT) && (rc == RC_BUSY);

    sdw_rsp_eval i_rsp_eval (
        .rsp_valid_i   (rsp_valid_i),
        .rsp_timeout_i (rsp_timeout_i),
        .rsp_data_i    (rsp_data_i),
        .dat0_i        (dat0_i),
        .rc_o          (rc)
    );

    sdw_poll_ctr #(.POLL_W(POLL_W)) i_poll_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .bump_i  (poll_bump),
        .limit_i (limit_q),
        .last_o  (poll_last)
    );

    sdw_cmd_build #(.RCA_W(RCA_W)) i_cmd_build (
        .sel_status_i (sel_status),
        .multi_i      (multi_q),
        .rca_i        (rca_q),
        .addr_i       (addr_q),
        .idx_o        (cmd_idx_o),
        .arg_o        (cmd_arg_o)
    );

    // Request parameters are captured only when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            multi_q <= 1'b0;
            addr_q  <= '0;
            nblk_q  <= '0;
            rca_q   <= '0;
            limit_q <= '0;
        end else if (accept) begin
            multi_q <= multi_i;
            addr_q  <= addr_i;
            nblk_q  <= nblk_i;
            rca_q   <= rca_i;
            limit_q <= poll_limit_i;
        end
    end

    // State register and held error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            code_q  <= E_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_POLL_CMD;
                    code_d  = E_NONE;
                end
            end
            S_POLL_CMD: begin
                if (cmd_ack_i) state_d = S_POLL_WAIT;
            end
            S_POLL_WAIT: begin
                unique case (rc)
                    RC_TMO:  begin state_d = S_FAIL; code_d = E_RSP_TMO;  end
                    RC_ERR:  begin state_d = S_FAIL; code_d = E_CARD_ERR; end
                    RC_GO:   state_d = S_WR_CMD;
                    RC_BUSY: begin
                        if (poll_last) begin
                            state_d = S_FAIL;
                            code_d  = E_POLL_TMO;
                        end else begin
                            state_d = S_POLL_CMD;
                        end
                    end
                    default: state_d = S_POLL_WAIT;
                endcase
            end
            S_WR_CMD: begin
                if (cmd_ack_i) state_d = S_WR_WAIT;
            end
            S_WR_WAIT: begin
                unique case (rc)
                    RC_TMO:  begin state_d = S_FAIL; code_d = E_RSP_TMO;  end
                    RC_ERR:  begin state_d = S_FAIL; code_d = E_CARD_ERR; end
                    RC_GO,
                    RC_BUSY: state_d = S_DATA;
                    default: state_d = S_WR_WAIT;
                endcase
            end
            S_DATA: begin
                if (dp_end_i) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            S_FAIL:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state alone.
    always_comb begin
        cmd_req_o  = (state_q == S_POLL_CMD) || (state_q == S_WR_CMD);
        sel_status = (state_q == S_POLL_CMD) || (state_q == S_POLL_WAIT);
        dp_en_o    = (state_q == S_DATA);
        done_o     = (state_q == S_FINISH);
        err_o      = (state_q == S_FAIL);
        err_code_o = code_q;
        dp_bsize_o = BSIZE_LOG2;
        dp_len_o   = multi_q ? (LEN_W'(nblk_q) << BLK_SHIFT) : ONE_BLK_LEN;
    end

    logic wr_req;
    assign wr_req = cmd_req_o && (cmd_idx_o != IDX_STATUS);

    // R2: a pending request holds its index and argument.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o && !cmd_ack_i |=> cmd_req_o && $stable(cmd_idx_o) && $stable(cmd_arg_o));

    // R3: a write command follows only a ready response with DAT0 high.
    p_wr_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rsp_valid_i && !rsp_timeout_i && rsp_data_i[READY_BIT] && dat0_i));

    // R5: data enable only after an error-free, in-time response.
    p_den_after_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_en_o) |-> $past(rsp_valid_i && !rsp_timeout_i && ((rsp_data_i & ERR_MASK) == 32'h0)));

    // R6: completion comes from data-end while the data path was enabled.
    p_done_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(dp_end_i && dp_en_o));

    // R8: an abort always carries a non-zero code.
    p_err_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != E_NONE));

    // R11: handshake outputs are mutually exclusive.
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_req_o, dp_en_o, done_o, err_o}));

endmodule

// File: tb/test_sd_wrstart_seq.sv
module test_sd_wrstart_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NBLK_W     = 8;
    localparam int POLL_W     = 4;
    localparam int RCA_W      = 16;
    localparam int LEN_W      = NBLK_W + 9;
    localparam int NV         = 13;

    typedef struct packed {
        int multi;
        int nblk;
        int limit;
        int busy;      // not-ready status responses (DAT0 low)
        int dlow;      // ready bit set but DAT0 still low
        int fault;     // 0 none,1 wr err bit,2 poll tmo,3 poll err bit,4 wr tmo,5 poll tmo+valid
        int poke;      // extra start while running
        int exp_code;
        int exp_polls;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{0,   1,  8, 0, 0, 0, 0, 0, 1},
        '{1,   3,  8, 2, 0, 0, 0, 0, 3},
        '{1,   5,  8, 1, 2, 0, 0, 0, 4},
        '{0,   1,  3, 5, 0, 0, 0, 1, 3},
        '{0,   1,  0, 1, 0, 0, 0, 1, 1},
        '{1,   2,  4, 3, 0, 0, 0, 0, 4},
        '{0,   1,  8, 0, 0, 3, 0, 2, 1},
        '{1,   2,  8, 0, 0, 1, 0, 2, 1},
        '{0,   1,  8, 0, 0, 2, 0, 3, 1},
        '{0,   1,  8, 0, 0, 4, 0, 3, 1},
        '{0,   1,  8, 0, 0, 5, 0, 3, 1},
        '{0,   1,  8, 1, 0, 0, 1, 0, 2},
        '{1, 255, 15, 4, 3, 0, 0, 0, 8}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic              multi_i;
    logic [31:0]       addr_i;
    logic [NBLK_W-1:0] nblk_i;
    logic [RCA_W-1:0]  rca_i;
    logic [POLL_W-1:0] poll_limit_i;
    logic              cmd_req_o;
    logic [5:0]        cmd_idx_o;
    logic [31:0]       cmd_arg_o;
    logic              cmd_ack_i;
    logic              rsp_valid_i;
    logic              rsp_timeout_i;
    logic [31:0]       rsp_data_i;
    logic              dat0_i;
    logic              dp_en_o;
    logic [LEN_W-1:0]  dp_len_o;
    logic [3:0]        dp_bsize_o;
    logic              dp_end_i;
    logic              done_o;
    logic              err_o;
    logic [1:0]        err_code_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_wrstart_seq #(.NBLK_W(NBLK_W), .POLL_W(POLL_W), .RCA_W(RCA_W)) i_sd_wrstart_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .multi_i(multi_i), .addr_i(addr_i),
        .nblk_i(nblk_i), .rca_i(rca_i), .poll_limit_i(poll_limit_i),
        .cmd_req_o(cmd_req_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o), .cmd_ack_i(cmd_ack_i),
        .rsp_valid_i(rsp_valid_i), .rsp_timeout_i(rsp_timeout_i), .rsp_data_i(rsp_data_i),
        .dat0_i(dat0_i), .dp_en_o(dp_en_o), .dp_len_o(dp_len_o), .dp_bsize_o(dp_bsize_o),
        .dp_end_i(dp_end_i), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic run_vec(input int v);
        vec_t   t = VECS[v];
        int     polls = 0;
        int     pend = 0;
        int     last_idx = 0;
        int     den = 0;
        int     code = -1;
        int     widx = -1;
        longint dlen = 0;
        int     dbs = 0;
        int     loops;
        bit     wr_seen = 0;
        bit     den_seen = 0;
        bit [31:0] waddr = 0;
        bit [31:0] addr = 32'h0000_1000 + 32'(v) * 32'h111;
        bit [15:0] rca = 16'hA5C3 ^ 16'(v);
        longint exp_len = t.multi ? longint'(t.nblk) * 512 : 512;
        string  code_tag;
        string  wr_tag = t.poke ? "R10" : "R4";

        @(negedge clk);
        start_i      = 1'b1;
        multi_i      = t.multi[0];
        addr_i       = addr;
        nblk_i       = t.nblk[NBLK_W-1:0];
        poll_limit_i = t.limit[POLL_W-1:0];
        rca_i        = rca;
        for (loops = 0; loops < 2000; loops++) begin
            @(negedge clk);
            start_i = 1'b0; cmd_ack_i = 1'b0; rsp_valid_i = 1'b0; rsp_timeout_i = 1'b0;
            dp_end_i = 1'b0; rsp_data_i = 32'h0; dat0_i = 1'b1;
            if (done_o) begin code = 0; break; end
            if (err_o) begin code = int'(err_code_o); break; end
            if (cmd_req_o) begin
                last_idx = int'(cmd_idx_o);
                if (cmd_idx_o == 6'd13) begin
                    polls++;
                    check(cmd_arg_o == {rca, 16'h0000}, "R2", "status arg", cmd_arg_o, {rca, 16'h0000});
                    if (t.poke != 0 && polls == 1) begin
                        start_i = 1'b1; multi_i = ~t.multi[0]; addr_i = 32'hDEAD_BEEF;
                    end
                end else begin
                    wr_seen = 1; widx = int'(cmd_idx_o); waddr = cmd_arg_o;
                end
                cmd_ack_i = 1'b1;
                pend = 3;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (last_idx == 13) begin
                        int k = polls - 1;
                        if (t.fault == 2 && k == 0) begin
                            rsp_timeout_i = 1'b1;
                        end else if (t.fault == 5 && k == 0) begin
                            rsp_timeout_i = 1'b1; rsp_valid_i = 1'b1; rsp_data_i = 32'h0000_0900;
                        end else if (t.fault == 3 && k == 0) begin
                            rsp_valid_i = 1'b1; rsp_data_i = 32'h0040_0900;
                        end else if (k < t.busy) begin
                            rsp_valid_i = 1'b1; rsp_data_i = 32'h0000_0E00; dat0_i = 1'b0;
                        end else if (k < t.busy + t.dlow) begin
                            rsp_valid_i = 1'b1; rsp_data_i = 32'h0000_0900; dat0_i = 1'b0;
                        end else begin
                            rsp_valid_i = 1'b1; rsp_data_i = 32'h0000_0900;
                        end
                    end else begin
                        if (t.fault == 4) rsp_timeout_i = 1'b1;
                        else if (t.fault == 1) begin rsp_valid_i = 1'b1; rsp_data_i = 32'h0400_0900; end
                        else begin rsp_valid_i = 1'b1; rsp_data_i = 32'h0000_0900; end
                    end
                end
            end
            if (dp_en_o) begin
                if (!den_seen) begin dlen = longint'(dp_len_o); dbs = int'(dp_bsize_o); end
                den_seen = 1;
                den++;
                if (den == 4) dp_end_i = 1'b1;
            end
        end
        check(loops < 2000, "R6", "sequence ended", loops, 0);
        case (t.exp_code)
            1: code_tag = "R7";
            2: code_tag = "R8";
            3: code_tag = "R9";
            default: code_tag = "R6";
        endcase
        check(code == t.exp_code, code_tag, "result code", code, t.exp_code);
        check(polls == t.exp_polls, (t.exp_code == 1) ? "R7" : "R3", "status polls", polls, t.exp_polls);
        if (t.exp_code == 0) begin
            check(widx == (t.multi ? 25 : 24), wr_tag, "write index", widx, t.multi ? 25 : 24);
            check(waddr == addr, wr_tag, "write arg", waddr, addr);
            check(dlen == exp_len, "R5", "data length", dlen, exp_len);
            check(dbs == 9, "R5", "block size code", dbs, 9);
            check(den == 4, "R6", "enable cycles", den, 4);
        end else begin
            check(!den_seen, (t.exp_code == 3) ? "R9" : "R8", "no data enable", den_seen, 0);
            if (t.exp_code == 1 || t.fault == 2 || t.fault == 3 || t.fault == 5)
                check(!wr_seen, "R7", "no write command", wr_seen, 0);
        end
        @(negedge clk);
        check(!done_o && !err_o && !cmd_req_o && !dp_en_o, "R6", "pulse one cycle, idle",
              {done_o, err_o, cmd_req_o, dp_en_o}, 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; multi_i = 1'b0; addr_i = '0; nblk_i = '0; rca_i = '0;
        poll_limit_i = '0; cmd_ack_i = 1'b0; rsp_valid_i = 1'b0; rsp_timeout_i = 1'b0;
        rsp_data_i = '0; dat0_i = 1'b1; dp_end_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({cmd_req_o, dp_en_o, done_o, err_o} == 4'b0, "R1", "outputs in reset",
              {cmd_req_o, dp_en_o, done_o, err_o}, 0);
        check(err_code_o == 2'd0, "R1", "code in reset", err_code_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({cmd_req_o, dp_en_o, done_o, err_o} == 4'b0, "R1", "idle after reset",
              {cmd_req_o, dp_en_o, done_o, err_o}, 0);

        for (int v = 0; v < NV; v++) begin
            run_vec(v);
        end

        // Directed: request held without ack keeps index and argument (R2).
        @(negedge clk);
        start_i = 1'b1; multi_i = 1'b0; addr_i = 32'h55; nblk_i = 8'd1; poll_limit_i = 4'd2; rca_i = 16'h0042;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        check(cmd_req_o && cmd_idx_o == 6'd13 && cmd_arg_o == 32'h0042_0000, "R2", "held request",
              cmd_arg_o, 32'h0042_0000);
        cmd_ack_i = 1'b1;
        @(negedge clk);
        cmd_ack_i = 1'b0;
        rsp_timeout_i = 1'b1;
        @(negedge clk);
        rsp_timeout_i = 1'b0;
        check(err_o && err_code_o == 2'd3, "R9", "late timeout", err_code_o, 3);
        @(negedge clk);
        check(!err_o && err_code_o == 2'd3, "R9", "code held after pulse", err_code_o, 3);

        finish_run();
    end

endmodule